// File: doc/BRIEF.md
# Hardwired Major/Timing State Controller

This block is the fixed-logic sequencer of a small load/store processor. Two registers hold its state: a two-bit major state that names the kind of machine cycle in progress, and a timing counter that steps through four phases, one per clock. From these two registers and the fields of the current instruction word (type and function), an externally evaluated branch condition and an interrupt request, combinational logic raises one strobe per control point. The control points are register load gates, memory read and write, PC increment, IR load, the PC save and vector load for interrupts, and an ALU operation selector.

Every machine cycle lasts exactly four timing states. The major state can change only on the last of them. Register-to-register and branch instructions complete within the fetch cycle. Loads and stores add one execute cycle. A pending interrupt, or an instruction word that decodes to nothing valid, sends the machine through an interrupt cycle before the next fetch. Memory is assumed to return read data within a fixed number of timing states, so the block has no ready handshake.

Top module: `ctl_hardwired`

## Requirements
- R1: While `rst` is high at a clock edge, the major state becomes fetch (`major_state` = 2'b00) and the timing state becomes 0; all strobes are then those of fetch phase 0.
- R2: The timing state increases by one on every clock edge outside reset and wraps from 3 to 0.
- R3: The major state is encoded as fetch 00, indirect 01, execute 10, interrupt 11. It changes only on the clock edge that ends timing state 3.
- R4: In fetch, phase 0 raises `mar_from_pc` and `mem_rd`, phase 1 raises `pc_inc`, and phase 2 raises `ir_load`; no other strobe is active in those phases.
- R5: Type code 3'b000 is functional, with function codes ADD 0000, SUB 0001, AND 0100, OR 0101 and SLL 1000. At fetch phase 3 such an instruction raises `rd_from_alu` and drives `alu_sel` to ADD=1, SUB=2, AND=3, OR=4 or SLL=5. `alu_sel` is 0 whenever no ALU result is used.
- R6: Type code 3'b010 is sequencing. At fetch phase 3, JMP (0000) raises `pc_from_alu` with `alu_sel`=ADD only when `cond_true` is 1. CALL (0001) raises `rd_from_pc` and `pc_from_alu`. RET (0010) raises `pc_from_alu`.
- R7: Type code 3'b101 is transfer, with load 0000 and store 0001. At fetch phase 3 it raises `mar_from_alu` with `alu_sel`=ADD, and the next major state is execute whatever the value of `irq`.
- R8: In execute, phase 0 raises `mem_rd` for a load or `mem_wr` for a store. Phase 1 raises `mbr_from_rd` for a store. Phase 2 raises `rd_from_mbr` for a load. `mem_rd` and `mem_wr` are never high together.
- R9: At the end of phase 3 of a fetch cycle for a non-transfer instruction, or of an execute cycle, the next major state is interrupt if `irq` is high in that phase and fetch otherwise.
- R10: An interrupt cycle raises `link_from_pc` in phase 0 and `pc_from_vec` in phase 1, and is always followed by fetch.
- R11: `irq` is sampled only in timing state 3. A request that is high only in phases 0 to 2 has no effect on the state sequence.
- R12: A type code outside the three valid codes, or a function code not listed for its type, raises `illegal` at fetch phase 3 with no register, PC or MAR strobe, and the next major state is interrupt.
- R13: The major state never takes the indirect encoding 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_type | input | 3 | Instruction type field of IR |
| ir_func | input | 4 | Instruction function field of IR |
| cond_true | input | 1 | Branch condition, evaluated outside from flags |
| irq | input | 1 | Interrupt request |
| major_state | output | 2 | Current major state |
| tstate | output | 2 | Current timing state |
| mar_from_pc | output | 1 | Load MAR from PC |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| pc_inc | output | 1 | PC advances by 4 |
| ir_load | output | 1 | Load IR from MBR |
| rd_from_alu | output | 1 | Write ALU result to Rd |
| rd_from_mbr | output | 1 | Write MBR to Rd |
| rd_from_pc | output | 1 | Write PC to Rd |
| mbr_from_rd | output | 1 | Load MBR from Rd |
| mar_from_alu | output | 1 | Load MAR from ALU (Rs1+S2) |
| pc_from_alu | output | 1 | Load PC from ALU (Rs1+S2) |
| link_from_pc | output | 1 | Save PC in the link register |
| pc_from_vec | output | 1 | Load PC with the interrupt vector |
| illegal | output | 1 | Unrecognised instruction |
| alu_sel | output | 3 | ALU operation select |

## Verification
Phase 3 of a fetch cycle is where two functions meet. The instruction's own writeback or branch strobe must be produced in the same cycle that the interrupt decision is taken. The bench raises `irq` during phase 3 of a SUB. It then requires both the `rd_from_alu` strobe with the SUB selector and a following interrupt cycle. During phase 3 of a load it requires that the request be overridden by the move to execute. A request held only in earlier phases, and an illegal word with no request, check each half of that decision separately.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int TYPE_W = 3;
    localparam int FUNC_W = 4;
    localparam int NUM_TS = 4;
    localparam int TS_W   = $clog2(NUM_TS);
    localparam logic [TS_W-1:0] TS_LAST = TS_W'(NUM_TS - 1);

    typedef enum logic [1:0] {
        MS_FETCH     = 2'b00,
        MS_INDIRECT  = 2'b01,
        MS_EXECUTE   = 2'b10,
        MS_INTERRUPT = 2'b11
    } major_e;

    localparam logic [TYPE_W-1:0] TY_FUNC = 3'b000;
    localparam logic [TYPE_W-1:0] TY_XFER = 3'b101;
    localparam logic [TYPE_W-1:0] TY_SEQ  = 3'b010;

    localparam logic [FUNC_W-1:0] FN_ADD   = 4'b0000;
    localparam logic [FUNC_W-1:0] FN_SUB   = 4'b0001;
    localparam logic [FUNC_W-1:0] FN_AND   = 4'b0100;
    localparam logic [FUNC_W-1:0] FN_OR    = 4'b0101;
    localparam logic [FUNC_W-1:0] FN_SLL   = 4'b1000;
    localparam logic [FUNC_W-1:0] FN_LOAD  = 4'b0000;
    localparam logic [FUNC_W-1:0] FN_STORE = 4'b0001;
    localparam logic [FUNC_W-1:0] FN_JMP   = 4'b0000;
    localparam logic [FUNC_W-1:0] FN_CALL  = 4'b0001;
    localparam logic [FUNC_W-1:0] FN_RET   = 4'b0010;

    typedef enum logic [2:0] {
        ALU_NONE = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_SLL  = 3'd5
    } alu_e;

    typedef enum logic [1:0] {
        SQ_NONE, SQ_JMP, SQ_CALL, SQ_RET
    } seq_e;

    typedef struct packed {
        logic is_func;
        logic is_xfer;
        logic is_seq;
        logic is_load;
        logic is_store;
        seq_e seq_kind;
        alu_e func_op;
        logic bad;
    } dec_t;

    typedef struct packed {
        logic mar_from_pc;
        logic mem_rd;
        logic mem_wr;
        logic pc_inc;
        logic ir_load;
        logic rd_from_alu;
        logic rd_from_mbr;
        logic rd_from_pc;
        logic mbr_from_rd;
        logic mar_from_alu;
        logic pc_from_alu;
        logic link_from_pc;
        logic pc_from_vec;
        logic illegal;
        alu_e alu_sel;
    } strobe_t;

    function automatic alu_e func_to_alu(input logic [FUNC_W-1:0] f);
        case (f)
            FN_ADD:  return ALU_ADD;
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLL:  return ALU_SLL;
            default: return ALU_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic [TYPE_W-1:0] ir_type,
    input  logic [FUNC_W-1:0] ir_func,
    output dec_t              dec
);
    always_comb begin
        dec = '0;
        case (ir_type)
            TY_FUNC: begin
                dec.func_op = func_to_alu(ir_func);
                dec.is_func = (dec.func_op != ALU_NONE);
                dec.bad     = (dec.func_op == ALU_NONE);
            end
            TY_XFER: begin
                dec.is_load  = (ir_func == FN_LOAD);
                dec.is_store = (ir_func == FN_STORE);
                dec.is_xfer  = dec.is_load | dec.is_store;
                dec.bad      = ~dec.is_xfer;
            end
            TY_SEQ: begin
                case (ir_func)
                    FN_JMP:  dec.seq_kind = SQ_JMP;
                    FN_CALL: dec.seq_kind = SQ_CALL;
                    FN_RET:  dec.seq_kind = SQ_RET;
                    default: dec.seq_kind = SQ_NONE;
                endcase
                dec.is_seq = (dec.seq_kind != SQ_NONE);
                dec.bad    = (dec.seq_kind == SQ_NONE);
            end
            default: dec.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            xfer_go,
    input  logic            trap,
    output major_e          major,
    output logic [TS_W-1:0] tstate
);
    major_e major_nxt;
    logic   last_ts;

    assign last_ts = (tstate == TS_LAST);

    always_comb begin
        case (major)
            MS_FETCH:     major_nxt = xfer_go ? MS_EXECUTE
                                    : (trap ? MS_INTERRUPT : MS_FETCH);
            MS_EXECUTE:   major_nxt = trap ? MS_INTERRUPT : MS_FETCH;
            MS_INTERRUPT: major_nxt = MS_FETCH;
            default:      major_nxt = MS_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            major  <= MS_FETCH;
            tstate <= '0;
        end else begin
            tstate <= last_ts ? '0 : tstate + 1'b1;
            if (last_ts)
                major <= major_nxt;
        end
    end

    assert_ts_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tstate != TS_LAST) |=> (tstate == $past(tstate) + 1'b1));
    assert_ts_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tstate == TS_LAST) |=> (tstate == '0));
    assert_major_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tstate != TS_LAST) |=> $stable(major));
    assert_no_indirect_R13: assert property (@(posedge clk) disable iff (rst)
        major != MS_INDIRECT);
    assert_int_returns_R10: assert property (@(posedge clk) disable iff (rst)
        (major == MS_INTERRUPT && tstate == TS_LAST) |=> (major == MS_FETCH));
endmodule

// File: rtl/ctl_strobes.sv
module ctl_strobes
    import ctl_pkg::*;
(
    input  major_e          major,
    input  logic [TS_W-1:0] tstate,
    input  dec_t            dec,
    input  logic            cond_true,
    output strobe_t         s
);
    always_comb begin
        s = '0;
        case (major)
            MS_FETCH: begin
                case (tstate)
                    TS_W'(0): begin s.mar_from_pc = 1'b1; s.mem_rd = 1'b1; end
                    TS_W'(1): s.pc_inc  = 1'b1;
                    TS_W'(2): s.ir_load = 1'b1;
                    default: begin
                        if (dec.is_func) begin
                            s.rd_from_alu = 1'b1;
                            s.alu_sel     = dec.func_op;
                        end
                        if (dec.is_xfer) begin
                            s.mar_from_alu = 1'b1;
                            s.alu_sel      = ALU_ADD;
                        end
                        if (dec.is_seq) begin
                            case (dec.seq_kind)
                                SQ_JMP: if (cond_true) begin
                                    s.pc_from_alu = 1'b1;
                                    s.alu_sel     = ALU_ADD;
                                end
                                SQ_CALL: begin
                                    s.rd_from_pc  = 1'b1;
                                    s.pc_from_alu = 1'b1;
                                    s.alu_sel     = ALU_ADD;
                                end
                                SQ_RET: begin
                                    s.pc_from_alu = 1'b1;
                                    s.alu_sel     = ALU_ADD;
                                end
                                default: ;
                            endcase
                        end
                        s.illegal = dec.bad;
                    end
                endcase
            end
            MS_EXECUTE: begin
                case (tstate)
                    TS_W'(0): begin
                        s.mem_rd = dec.is_load;
                        s.mem_wr = dec.is_store;
                    end
                    TS_W'(1): s.mbr_from_rd = dec.is_store;
                    TS_W'(2): s.rd_from_mbr = dec.is_load;
                    default: ;
                endcase
            end
            MS_INTERRUPT: begin
                case (tstate)
                    TS_W'(0): s.link_from_pc = 1'b1;
                    TS_W'(1): s.pc_from_vec  = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_hardwired.sv
module ctl_hardwired
    import ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  ir_type,
    input  logic [3:0]  ir_func,
    input  logic        cond_true,
    input  logic        irq,
    output logic [1:0]  major_state,
    output logic [1:0]  tstate,
    output logic        mar_from_pc,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        pc_inc,
    output logic        ir_load,
    output logic        rd_from_alu,
    output logic        rd_from_mbr,
    output logic        rd_from_pc,
    output logic        mbr_from_rd,
    output logic        mar_from_alu,
    output logic        pc_from_alu,
    output logic        link_from_pc,
    output logic        pc_from_vec,
    output logic        illegal,
    output logic [2:0]  alu_sel
);
    major_e          major;
    logic [TS_W-1:0] ts;
    dec_t            dec;
    strobe_t         s;
    logic            in_fetch;

    assign in_fetch = (major == MS_FETCH);

    ctl_decode u_decode (
        .ir_type (ir_type),
        .ir_func (ir_func),
        .dec     (dec)
    );

    ctl_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .xfer_go (in_fetch & dec.is_xfer),
        .trap    (irq | (in_fetch & dec.bad)),
        .major   (major),
        .tstate  (ts)
    );

    ctl_strobes u_strobes (
        .major     (major),
        .tstate    (ts),
        .dec       (dec),
        .cond_true (cond_true),
        .s         (s)
    );

    assign major_state  = major;
    assign tstate       = ts;
    assign mar_from_pc  = s.mar_from_pc;
    assign mem_rd       = s.mem_rd;
    assign mem_wr       = s.mem_wr;
    assign pc_inc       = s.pc_inc;
    assign ir_load      = s.ir_load;
    assign rd_from_alu  = s.rd_from_alu;
    assign rd_from_mbr  = s.rd_from_mbr;
    assign rd_from_pc   = s.rd_from_pc;
    assign mbr_from_rd  = s.mbr_from_rd;
    assign mar_from_alu = s.mar_from_alu;
    assign pc_from_alu  = s.pc_from_alu;
    assign link_from_pc = s.link_from_pc;
    assign pc_from_vec  = s.pc_from_vec;
    assign illegal      = s.illegal;
    assign alu_sel      = s.alu_sel;

    assert_mem_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(rd_from_alu || pc_from_alu || mar_from_alu || rd_from_pc));
    assert_illegal_traps_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (major_state == 2'b11));
    assert_xfer_to_exec_R7: assert property (@(posedge clk) disable iff (rst)
        mar_from_alu |=> (major_state == 2'b10));
    assert_exec_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (major_state == 2'b10 && tstate == 2'd3)
        |=> (major_state == ($past(irq) ? 2'b11 : 2'b00)));
endmodule

// File: tb/ctl_hardwired_bench.sv
module ctl_hardwired_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] ir_type = 3'b000;
    logic [3:0] ir_func = 4'b0000;
    logic cond_true = 1'b0;
    logic irq = 1'b0;
    logic [1:0] major_state, tstate;
    logic mar_from_pc, mem_rd, mem_wr, pc_inc, ir_load, rd_from_alu, rd_from_mbr;
    logic rd_from_pc, mbr_from_rd, mar_from_alu, pc_from_alu, link_from_pc;
    logic pc_from_vec, illegal;
    logic [2:0] alu_sel;

    int checks = 0;
    int errors = 0;

    localparam logic [13:0] S_NONE = 14'd0;
    localparam logic [13:0] S_MARPC = 14'h2000, S_MRD = 14'h1000, S_MWR = 14'h0800;
    localparam logic [13:0] S_PCINC = 14'h0400, S_IRLD = 14'h0200, S_RDALU = 14'h0100;
    localparam logic [13:0] S_RDMBR = 14'h0080, S_RDPC = 14'h0040, S_MBRRD = 14'h0020;
    localparam logic [13:0] S_MARALU = 14'h0010, S_PCALU = 14'h0008, S_LINK = 14'h0004;
    localparam logic [13:0] S_VEC = 14'h0002, S_ILL = 14'h0001;
    localparam logic [1:0] M_FET = 2'b00, M_EXE = 2'b10, M_INT = 2'b11;

    ctl_hardwired u_ctl_hardwired (
        .clk(clk), .rst(rst), .ir_type(ir_type), .ir_func(ir_func),
        .cond_true(cond_true), .irq(irq), .major_state(major_state),
        .tstate(tstate), .mar_from_pc(mar_from_pc), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .pc_inc(pc_inc), .ir_load(ir_load),
        .rd_from_alu(rd_from_alu), .rd_from_mbr(rd_from_mbr),
        .rd_from_pc(rd_from_pc), .mbr_from_rd(mbr_from_rd),
        .mar_from_alu(mar_from_alu), .pc_from_alu(pc_from_alu),
        .link_from_pc(link_from_pc), .pc_from_vec(pc_from_vec),
        .illegal(illegal), .alu_sel(alu_sel)
    );

    always #4 clk = ~clk;

    function automatic logic [13:0] strobes();
        return {mar_from_pc, mem_rd, mem_wr, pc_inc, ir_load, rd_from_alu,
                rd_from_mbr, rd_from_pc, mbr_from_rd, mar_from_alu,
                pc_from_alu, link_from_pc, pc_from_vec, illegal};
    endfunction

    // R13: the indirect encoding never appears
    always @(negedge clk) if (!rst) begin
        checks++;
        if (major_state == 2'b01) begin
            errors++;
            $display("FAIL R13 major=%b expected not 01", major_state);
        end
    end

    task automatic expect_st(input logic [1:0] m, input logic [1:0] t,
                             input logic [13:0] sv, input logic [2:0] a,
                             input string tag);
        checks++;
        if (major_state !== m || tstate !== t || strobes() !== sv || alu_sel !== a) begin
            errors++;
            $display("FAIL %s actual m=%b t=%0d s=%h alu=%0d expected m=%b t=%0d s=%h alu=%0d",
                     tag, major_state, tstate, strobes(), alu_sel, m, t, sv, a);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Fetch phases 0..2, leaves the bench at fetch phase 3 (R4, R2)
    task automatic fetch_to_t3(input logic [2:0] ty, input logic [3:0] fn,
                               input logic irq_early);
        ir_type = ty; ir_func = fn; irq = irq_early;
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R4 fetch t0");
        step();
        expect_st(M_FET, 2'd1, S_PCINC, 3'd0, "R4 fetch t1");
        step();
        expect_st(M_FET, 2'd2, S_IRLD, 3'd0, "R4 fetch t2 R2");
        step();
        irq = 1'b0;
    endtask

    task automatic int_cycle();
        expect_st(M_INT, 2'd0, S_LINK, 3'd0, "R10 int t0");
        step();
        expect_st(M_INT, 2'd1, S_VEC, 3'd0, "R10 int t1");
        step();
        expect_st(M_INT, 2'd2, S_NONE, 3'd0, "R10 int t2");
        step();
        irq = 1'b1;  // ignored, interrupt always returns to fetch
        expect_st(M_INT, 2'd3, S_NONE, 3'd0, "R10 int t3");
        step();
        irq = 1'b0;
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R10 back to fetch");
    endtask

    task automatic t_reset();
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R1 reset state");
    endtask

    task automatic t_functional(input logic [3:0] fn, input logic [2:0] a);
        fetch_to_t3(3'b000, fn, 1'b0);
        expect_st(M_FET, 2'd3, S_RDALU, a, "R5 functional t3");
        step();
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R9 R3 stays fetch");
    endtask

    task automatic t_func_with_irq();
        fetch_to_t3(3'b000, 4'b0001, 1'b0);
        irq = 1'b1;
        #1;
        expect_st(M_FET, 2'd3, S_RDALU, 3'd2, "R5 R9 sub with irq t3");
        step();
        irq = 1'b0;
        int_cycle();
    endtask

    task automatic t_early_irq();
        fetch_to_t3(3'b000, 4'b0000, 1'b1);
        expect_st(M_FET, 2'd3, S_RDALU, 3'd1, "R11 add t3");
        step();
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R11 early irq ignored");
    endtask

    task automatic t_seq(input logic [3:0] fn, input logic c,
                         input logic [13:0] sv, input logic [2:0] a);
        cond_true = c;
        fetch_to_t3(3'b010, fn, 1'b0);
        expect_st(M_FET, 2'd3, sv, a, "R6 sequencing t3");
        step();
        cond_true = 1'b0;
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R6 R9 next fetch");
    endtask

    task automatic t_load();
        fetch_to_t3(3'b101, 4'b0000, 1'b0);
        irq = 1'b1;
        #1;
        expect_st(M_FET, 2'd3, S_MARALU, 3'd1, "R7 load t3");
        step();
        irq = 1'b0;
        expect_st(M_EXE, 2'd0, S_MRD, 3'd0, "R7 R8 exe load t0");
        step();
        expect_st(M_EXE, 2'd1, S_NONE, 3'd0, "R8 exe load t1");
        step();
        expect_st(M_EXE, 2'd2, S_RDMBR, 3'd0, "R8 exe load t2");
        step();
        expect_st(M_EXE, 2'd3, S_NONE, 3'd0, "R8 exe load t3");
        step();
        expect_st(M_FET, 2'd0, S_MARPC | S_MRD, 3'd0, "R9 exe to fetch");
    endtask

    task automatic t_store();
        fetch_to_t3(3'b101, 4'b0001, 1'b0);
        expect_st(M_FET, 2'd3, S_MARALU, 3'd1, "R7 store t3");
        step();
        expect_st(M_EXE, 2'd0, S_MWR, 3'd0, "R8 exe store t0");
        step();
        expect_st(M_EXE, 2'd1, S_MBRRD, 3'd0, "R8 exe store t1");
        step();
        expect_st(M_EXE, 2'd2, S_NONE, 3'd0, "R8 exe store t2");
        step();
        irq = 1'b1;
        #1;
        expect_st(M_EXE, 2'd3, S_NONE, 3'd0, "R9 exe store t3 irq");
        step();
        irq = 1'b0;
        int_cycle();
    endtask

    task automatic t_illegal(input logic [2:0] ty, input logic [3:0] fn);
        fetch_to_t3(ty, fn, 1'b0);
        expect_st(M_FET, 2'd3, S_ILL, 3'd0, "R12 illegal t3");
        step();
        int_cycle();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_functional(4'b0000, 3'd1);
        t_functional(4'b0100, 3'd3);
        t_functional(4'b0101, 3'd4);
        t_functional(4'b1000, 3'd5);
        t_func_with_irq();
        t_early_irq();
        t_seq(4'b0000, 1'b1, S_PCALU, 3'd1);
        t_seq(4'b0000, 1'b0, S_NONE, 3'd0);
        t_seq(4'b0001, 1'b0, S_RDPC | S_PCALU, 3'd1);
        t_seq(4'b0010, 1'b0, S_PCALU, 3'd1);
        t_load();
        t_store();
        t_illegal(3'b111, 4'b0000);
        t_illegal(3'b000, 4'b0010);
        t_illegal(3'b101, 4'b0011);
        // R1: reset mid-cycle returns to fetch phase 0
        step();
        step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule